// File: doc/BRIEF.md
# Reader Power Mode Controller

This block sequences the power states of a contactless reader front end. It decides when the core regulators and the main oscillator run, when the pads are isolated, when the transmitter and receiver may operate, and when the device is ready to answer the host. It runs on the always-on low-frequency clock. A dedicated pin forces hard power-down. A host-written standby bit puts the device into a low-power standby that keeps all stored state. A modem-off bit switches only the radio path off.

A start-up timer runs after every wake, and the ready flag stays low until it completes. There are two ways out of standby: the host clears the standby bit, or it sends the wake byte 0x55 over the serial link. In the second case the controller pulses a clear request back to the standby bit. Read requests go unanswered while ready is low, so a host can poll address 0 until a read returns data. Leaving hard power-down also pulses the clear request, so the device resumes full operation rather than standby.

Top module: `rdr_pwr_ctrl`

## Requirements
- R1: While reset is held, and after it is released, the controller is in start-up: regulators and oscillator enabled, clamp and tri-state low, transmitter and receiver off, ready low.
- R2: A high power-down pin moves the controller to hard-off at the next clock edge, from any state and also in the middle of start-up. In hard-off, regulators and oscillator are off, clamp and tri-state are high, and transmitter, receiver and ready are low.
- R3: In hard-off, the standby bit, the modem-off bit and serial bytes have no effect on any output.
- R4: At the first edge with the pin low in hard-off, the controller enters start-up, and the standby-clear output is high for exactly that one cycle.
- R5: Start-up lasts STARTUP_CYC clock cycles, which is 15 at the defaults (15 us at 1 MHz). Ready rises at the STARTUP_CYC-th edge after start-up is entered.
- R6: When ready and the standby bit is high, the next edge enters standby. In standby, regulators and oscillator are off, clamp and tri-state are low, and transmitter, receiver and ready are low.
- R7: Clearing the standby bit while in standby enters start-up at the next edge, without a standby-clear pulse.
- R8: A serial byte of value 0x55 received while in standby enters start-up at the next edge and gives a one-cycle standby-clear pulse. Other byte values in standby, and 0x55 outside standby, have no effect.
- R9: A read request is acknowledged in the same cycle only when ready is high. While ready is low, reads are not acknowledged.
- R10: While ready, the transmitter and receiver enables equal the inverse of the modem-off bit. The modem-off bit changes no other output.
- R11: A standby bit that is set during start-up does not shorten it. Standby is entered one edge after ready rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency always-on clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pdn_i | input | 1 | Hard power-down pin, active high |
| stby_bit_i | input | 1 | Standby bit from the command register |
| modem_off_i | input | 1 | Modem-off bit from the control register |
| rx_valid_i | input | 1 | Serial host byte strobe |
| rx_byte_i | input | BYTE_W | Received serial host byte |
| rd_req_i | input | 1 | Host register read request |
| rd_ack_o | output | 1 | Read request answered |
| reg_en_o | output | 1 | Core regulator enable |
| osc_en_o | output | 1 | Main oscillator enable |
| in_clamp_o | output | 1 | Digital input isolation and clamp |
| out_hiz_o | output | 1 | Output pad tri-state control |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| ready_o | output | 1 | Full operation reached |
| stby_clr_o | output | 1 | One-cycle request to clear the standby bit |

## Verification
The hardest cases to reach from the ports are a wake that is cut short and a standby request that arrives before ready. The stimulus raises the power-down pin five cycles into a start-up. Separately, it sets the standby bit while start-up is running and holds it there. In both cases the per-cycle reference model shows whether the timer restarts from zero and whether standby waits for the full count. The bench also sends the near-miss bytes 0x54 and 0xAA in standby, and 0x55 outside standby, to show that only the exact wake byte in the right state counts.

// File: rtl/rdr_pwr_pkg.sv
package rdr_pwr_pkg;

   typedef enum logic [1:0] {
      PM_HARD_OFF = 2'd0,
      PM_WAKING   = 2'd1,
      PM_RUN      = 2'd2,
      PM_DOZE     = 2'd3
   } pm_state_e;

   typedef struct packed {
      logic reg_en;
      logic osc_en;
      logic in_clamp;
      logic out_hiz;
      logic tx_en;
      logic rx_en;
      logic ready;
   } pm_outs_t;

endpackage

// File: rtl/rdr_pwr_timer.sv
module rdr_pwr_timer #(
   parameter int unsigned STARTUP_CYC = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);

   localparam int unsigned CNT_W = (STARTUP_CYC > 2) ? $clog2(STARTUP_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(STARTUP_CYC - 1);

   generate
      if (STARTUP_CYC < 2) begin : g_bad_cyc
         $error("rdr_pwr_timer: STARTUP_CYC must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign done_o = run_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i || done_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R5
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R5
   cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> cnt_q == '0);

endmodule

// File: rtl/rdr_pwr_wake_det.sv
module rdr_pwr_wake_det #(
   parameter int unsigned          BYTE_W    = 8,
   parameter logic [BYTE_W-1:0]    WAKE_CODE = 8'h55,
   parameter bit                   PIPE      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic              hit_o
);

   generate
      if (BYTE_W < 1) begin : g_bad_w
         $error("rdr_pwr_wake_det: BYTE_W must be positive");
      end
   endgenerate

   logic match;
   assign match = valid_i && (byte_i == WAKE_CODE);

   generate
      if (PIPE) begin : g_reg
         logic hit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hit_q <= 1'b0;
            else        hit_q <= match;
         end
         assign hit_o = hit_q;
      end else begin : g_comb
         assign hit_o = match;
      end
   endgenerate

endmodule

// File: rtl/rdr_pwr_fsm.sv
module rdr_pwr_fsm
   import rdr_pwr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pdn_i,
   input  logic      stby_bit_i,
   input  logic      wake_hit_i,
   input  logic      su_done_i,
   output pm_state_e state_o,
   output logic      stby_clr_o
);

   pm_state_e st_q, st_d;
   logic      clr_q, clr_d;

   always_comb begin
      st_d  = st_q;
      clr_d = 1'b0;
      if (pdn_i) begin
         st_d = PM_HARD_OFF;
      end else begin
         unique case (st_q)
            PM_HARD_OFF: begin
               st_d  = PM_WAKING;
               clr_d = 1'b1;
            end
            PM_WAKING: begin
               if (su_done_i) st_d = PM_RUN;
            end
            PM_RUN: begin
               if (stby_bit_i) st_d = PM_DOZE;
            end
            PM_DOZE: begin
               if (wake_hit_i) begin
                  st_d  = PM_WAKING;
                  clr_d = 1'b1;
               end else if (!stby_bit_i) begin
                  st_d = PM_WAKING;
               end
            end
            default: st_d = PM_HARD_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= PM_WAKING;
         clr_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         clr_q <= clr_d;
      end
   end

   assign state_o    = st_q;
   assign stby_clr_o = clr_q;

   // R2
   pdn_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pdn_i |=> st_q == PM_HARD_OFF);

   // R4
   pdn_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PM_HARD_OFF && !pdn_i) |=> (st_q == PM_WAKING && clr_q));

   // R5
   wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PM_WAKING && !su_done_i && !pdn_i) |=> st_q == PM_WAKING);

   // R8
   wake_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PM_DOZE && wake_hit_i && !pdn_i) |=> (st_q == PM_WAKING && clr_q));

   // R7
   stby_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PM_DOZE && !stby_bit_i && !wake_hit_i && !pdn_i) |=> (st_q == PM_WAKING && !clr_q));

endmodule

// File: rtl/rdr_pwr_outdec.sv
module rdr_pwr_outdec
   import rdr_pwr_pkg::*;
(
   input  pm_state_e state_i,
   input  logic      modem_off_i,
   output pm_outs_t  outs_o
);

   always_comb begin
      outs_o = '0;
      unique case (state_i)
         PM_HARD_OFF: begin
            outs_o.in_clamp = 1'b1;
            outs_o.out_hiz  = 1'b1;
         end
         PM_WAKING: begin
            outs_o.reg_en = 1'b1;
            outs_o.osc_en = 1'b1;
         end
         PM_RUN: begin
            outs_o.reg_en = 1'b1;
            outs_o.osc_en = 1'b1;
            outs_o.tx_en  = !modem_off_i;
            outs_o.rx_en  = !modem_off_i;
            outs_o.ready  = 1'b1;
         end
         PM_DOZE: begin
            outs_o = '0;
         end
         default: outs_o = '0;
      endcase
   end

endmodule

// File: rtl/rdr_pwr_ctrl.sv
module rdr_pwr_ctrl
   import rdr_pwr_pkg::*;
#(
   parameter int unsigned       CLK_KHZ    = 1000,
   parameter int unsigned       STARTUP_NS = 15000,
   parameter int unsigned       BYTE_W     = 8,
   parameter logic [BYTE_W-1:0] WAKE_CODE  = 8'h55,
   parameter bit                WAKE_PIPE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pdn_i,
   input  logic              stby_bit_i,
   input  logic              modem_off_i,
   input  logic              rx_valid_i,
   input  logic [BYTE_W-1:0] rx_byte_i,
   input  logic              rd_req_i,
   output logic              rd_ack_o,
   output logic              reg_en_o,
   output logic              osc_en_o,
   output logic              in_clamp_o,
   output logic              out_hiz_o,
   output logic              tx_en_o,
   output logic              rx_en_o,
   output logic              ready_o,
   output logic              stby_clr_o
);

   localparam int unsigned STARTUP_CYC = (STARTUP_NS * CLK_KHZ + 999999) / 1000000;

   generate
      if (CLK_KHZ == 0) begin : g_bad_clk
         $error("rdr_pwr_ctrl: CLK_KHZ must be positive");
      end
   endgenerate

   pm_state_e state;
   pm_outs_t  outs;
   logic      su_done;
   logic      wake_hit;

   rdr_pwr_wake_det #(
      .BYTE_W   (BYTE_W),
      .WAKE_CODE(WAKE_CODE),
      .PIPE     (WAKE_PIPE)
   ) i_wake (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid_i(rx_valid_i),
      .byte_i (rx_byte_i),
      .hit_o  (wake_hit)
   );

   rdr_pwr_timer #(
      .STARTUP_CYC(STARTUP_CYC)
   ) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (state == PM_WAKING),
      .done_o(su_done)
   );

   rdr_pwr_fsm i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .pdn_i     (pdn_i),
      .stby_bit_i(stby_bit_i),
      .wake_hit_i(wake_hit),
      .su_done_i (su_done),
      .state_o   (state),
      .stby_clr_o(stby_clr_o)
   );

   rdr_pwr_outdec i_dec (
      .state_i    (state),
      .modem_off_i(modem_off_i),
      .outs_o     (outs)
   );

   assign reg_en_o   = outs.reg_en;
   assign osc_en_o   = outs.osc_en;
   assign in_clamp_o = outs.in_clamp;
   assign out_hiz_o  = outs.out_hiz;
   assign tx_en_o    = outs.tx_en;
   assign rx_en_o    = outs.rx_en;
   assign ready_o    = outs.ready;
   assign rd_ack_o   = rd_req_i && outs.ready;

   // R9
   read_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack_o |-> state == PM_RUN);

   // R5
   ready_after_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_WAKING && su_done && !pdn_i) |=> ready_o);

   // R2
   pad_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_clamp_o |-> (out_hiz_o && !reg_en_o && !osc_en_o && !tx_en_o && !rx_en_o));

endmodule

// File: tb/test_rdr_pwr_ctrl.sv
module test_rdr_pwr_ctrl;

   localparam int CYC = 15;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pdn = 1'b0, stby = 1'b0, modem_off = 1'b0;
   logic       rx_valid = 1'b0, rd_req = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       rd_ack, reg_en, osc_en, in_clamp, out_hiz, tx_en, rx_en, ready, stby_clr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model: 0 hard-off, 1 waking, 2 run, 3 doze
   int mst = 1;
   int mcnt = 0;
   bit mclr = 1'b0;

   always #5 clk = ~clk;

   rdr_pwr_ctrl i_rdr_pwr_ctrl (
      .clk(clk), .rst_n(rst_n), .pdn_i(pdn), .stby_bit_i(stby),
      .modem_off_i(modem_off), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
      .rd_req_i(rd_req), .rd_ack_o(rd_ack), .reg_en_o(reg_en), .osc_en_o(osc_en),
      .in_clamp_o(in_clamp), .out_hiz_o(out_hiz), .tx_en_o(tx_en), .rx_en_o(rx_en),
      .ready_o(ready), .stby_clr_o(stby_clr)
   );

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      int ns;
      bit nc;
      if (!rst_n) begin
         mst = 1; mcnt = 0; mclr = 1'b0;
      end else begin
         ns = mst; nc = 1'b0;
         if (pdn) ns = 0;
         else begin
            case (mst)
               0: begin ns = 1; nc = 1'b1; end
               1: if (mcnt == CYC - 1) ns = 2;
               2: if (stby) ns = 3;
               default: begin
                  if (rx_valid && rx_byte == 8'h55) begin ns = 1; nc = 1'b1; end
                  else if (!stby) ns = 1;
               end
            endcase
         end
         if (ns == 1 && mst == 1) mcnt = mcnt + 1;
         else mcnt = 0;
         mst = ns;
         mclr = nc;
      end
   end

   always @(posedge clk) begin
      string tag;
      #2;
      if (rst_n && !done) begin
         tag = (mst == 0) ? "R2/R3" : (mst == 1) ? "R5/R11" : (mst == 2) ? "R10" : "R6/R7/R8";
         chk(tag, "reg_en",   reg_en,   mst == 1 || mst == 2);
         chk(tag, "osc_en",   osc_en,   mst == 1 || mst == 2);
         chk(tag, "in_clamp", in_clamp, mst == 0);
         chk(tag, "out_hiz",  out_hiz,  mst == 0);
         chk(tag, "tx_en",    tx_en,    mst == 2 && !modem_off);
         chk(tag, "rx_en",    rx_en,    mst == 2 && !modem_off);
         chk(tag, "ready",    ready,    mst == 2);
         chk("R4/R8", "stby_clr", stby_clr, mclr);
         chk("R9", "rd_ack", rd_ack, rd_req && mst == 2);
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk); rx_valid = 1'b1; rx_byte = b;
      @(negedge clk); rx_valid = 1'b0; rx_byte = 8'h00;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      wait_n(3);
      // R1: start-up state under reset
      chk("R1", "reg_en",   reg_en,   1'b1);
      chk("R1", "osc_en",   osc_en,   1'b1);
      chk("R1", "in_clamp", in_clamp, 1'b0);
      chk("R1", "out_hiz",  out_hiz,  1'b0);
      chk("R1", "tx_en",    tx_en,    1'b0);
      chk("R1", "ready",    ready,    1'b0);
      rst_n = 1'b1;
      // R9: poll reads through the first start-up, R5 timing
      rd_req = 1'b1;
      wait_n(CYC + 4);
      // R10: modem off only touches the radio
      modem_off = 1'b1; wait_n(3);
      modem_off = 1'b0; wait_n(2);
      // R8: wake byte outside standby is ignored
      send(8'h55); wait_n(2);
      // R6: enter standby, R8 near-miss bytes then the wake byte
      stby = 1'b1; wait_n(3);
      send(8'h54); send(8'hAA); wait_n(2);
      @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h55;
      @(negedge clk); rx_valid = 1'b0; stby = 1'b0;
      wait_n(CYC + 3);
      // R7: leave standby by clearing the bit
      stby = 1'b1; wait_n(3);
      stby = 1'b0; wait_n(CYC + 3);
      // R2/R3: hard power-down from run, inputs ignored
      pdn = 1'b1; wait_n(2);
      stby = 1'b1; modem_off = 1'b1; send(8'h55); wait_n(2);
      stby = 1'b0; modem_off = 1'b0; wait_n(1);
      // R4: release, then R2 abort mid start-up
      pdn = 1'b0; wait_n(5);
      pdn = 1'b1; wait_n(3);
      pdn = 1'b0; wait_n(5);
      // R11: standby bit set during start-up
      stby = 1'b1; wait_n(CYC + 4);
      // R2 from standby, R4 clear request
      pdn = 1'b1; wait_n(2);
      pdn = 1'b0;
      @(negedge clk); stby = 1'b0;
      wait_n(CYC + 4);
      rd_req = 1'b0; wait_n(2);
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

endmodule